// File: doc/BRIEF.md
# LCD Column Line Capture

This block gathers one display line of column data for a segment driver that can be chained with other drivers of the same kind. A line pulse clears the capture logic. The block then ignores the data bus until its enable input is seen low on a shift strobe. After that it takes either one nibble or one byte on each shift strobe. It pairs nibbles into bytes and writes each byte into the next 8-bit slot of a 160-bit data latch. A one-hot pointer selects the slot, and it moves up from slot 0 or down from slot 19.

After the twentieth byte is written, the block deselects itself. It drives its active-low cascade output so that the next driver in the chain begins to accept data, and it ignores any further strobes. When the line pulse falls, the whole data latch is copied into the line latch output in one cycle. The line latch holds that value while the next line is captured.

Everything runs on one system clock. The shift clock arrives as a one-cycle strobe that marks its falling edge. The line pulse is sampled as a level, and its falling edge is found by comparing it with its value one clock earlier.

Top module: `lcdcap_column_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, `line_out` becomes all zeros, `casc_out_n` becomes 1 and every data latch slot becomes zero.
- R2: With `bus_byte` = 1, each accepted strobe writes `din[7:0]` as one whole byte into the slot the pointer selects, and then the pointer advances.
- R3: With `bus_byte` = 0, each accepted strobe takes only `din[3:0]`. The first strobe of a pair gives the low nibble and the second gives the high nibble, and the byte is written on the second strobe.
- R4: Slot k occupies bits 8k+7..8k of the latch and of `line_out`. With `scan_down` = 0, a line fills slots 0,1,…,19. With `scan_down` = 1, it fills slots 19,18,…,0.
- R5: After a line pulse, strobes are ignored while `en_in_n` is high. The first strobe with `en_in_n` low is accepted, and later strobes are accepted whatever the level of `en_in_n`.
- R6: `casc_out_n` goes low on the clock edge that follows the sampling of the strobe that writes the twentieth byte. It stays low until a clock edge sees `line_pulse` high.
- R7: After the line is full, further strobes leave the data latch unchanged.
- R8: `line_out` changes only on the clock edge where `line_pulse` is sampled low after being sampled high one edge earlier. On that edge it loads all 160 latch bits at once. At all other times it holds its value, including during the capture of a new line.
- R9: While `line_pulse` is high, strobes are ignored and the capture logic is cleared: the enable state, the nibble pairing and the slot pointer are reset. A line that was cut off partway therefore starts over at its first slot and its first nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | Line pulse. High clears the capture logic, and the falling edge transfers the latch |
| en_in_n | input | 1 | Active-low enable from the previous driver in the chain |
| shift_stb | input | 1 | One-cycle strobe that marks a falling edge of the shift clock |
| bus_byte | input | 1 | 1 selects byte-wide input, 0 selects nibble-wide input on din[3:0] |
| scan_down | input | 1 | 0 fills slots upward from 0, 1 fills them downward from 19 |
| din | input | 8 | Column data bus |
| casc_out_n | output | 1 | Active-low enable to the next driver in the chain |
| line_out | output | 160 | Line latch output, slot k at bits 8k+7..8k |

## Verification
The assertions assume that `scan_down` and `bus_byte` change only while `line_pulse` is high. They also assume that `shift_stb` is a single-cycle pulse, so that each strobe counts once. The stimulus changes mode and direction only inside a line pulse, and it separates strobes with idle cycles. It never places a strobe on the cycle where the line pulse falls, so a byte write and a line transfer never happen on the same edge.

// File: rtl/lcdcap_pkg.sv
// Package: shared constants and mode encodings for the column capture block.
// Assumes: one system clock drives every module of the block.
package lcdcap_pkg;

    // Width of one latch slot, which is one assembled byte.
    localparam int unsigned SLOT_BITS = 8;

    // Encoding of the bus width select.
    typedef enum logic {
        BUS_NIBBLE = 1'b0,
        BUS_BYTE   = 1'b1
    } bus_mode_e;

    // Encoding of the pointer travel direction.
    typedef enum logic {
        SCAN_UP   = 1'b0,
        SCAN_DOWN = 1'b1
    } scan_dir_e;

endpackage

// File: rtl/lcdcap_bus_conv.sv
// Module: lcdcap_bus_conv
// Turns accepted strobes into bytes. In byte mode every take yields the
// whole bus. In nibble mode a take with phase 0 stores the low nibble and
// a take with phase 1 produces {new nibble, stored nibble}.
// Assumes: take is high for one cycle per strobe, and clr clears the pairing.
module lcdcap_bus_conv
    import lcdcap_pkg::*;
#(
    parameter int unsigned SLOT_W = SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              byte_mode,
    input  logic [SLOT_W-1:0] din,
    output logic              byte_vld,
    output logic [SLOT_W-1:0] byte_val
);

    localparam int unsigned HALF_W = SLOT_W / 2;

    logic              phase_q;
    logic [HALF_W-1:0] low_q;

    // Nibble pairing state: remember the low nibble and which half comes next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            low_q   <= '0;
        end else if (clr) begin
            phase_q <= 1'b0;
        end else if (take && (bus_mode_e'(byte_mode) == BUS_NIBBLE)) begin
            if (!phase_q) begin
                low_q <= din[HALF_W-1:0];
            end
            phase_q <= ~phase_q;
        end
    end

    // Byte output: whole bus in byte mode, joined nibbles in nibble mode.
    always_comb begin
        if (bus_mode_e'(byte_mode) == BUS_BYTE) begin
            byte_vld = take;
            byte_val = din;
        end else begin
            byte_vld = take & phase_q;
            byte_val = {din[HALF_W-1:0], low_q};
        end
    end

    // In nibble mode no two consecutive takes may both produce a byte.
    assert_nibble_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_mode && !clr) |=> !(byte_vld && !byte_mode));

endmodule

// File: rtl/lcdcap_slot_ptr.sv
// Module: lcdcap_slot_ptr
// One-hot pointer over the latch slots. clr loads the first slot for the
// chosen direction. Each adv moves the pointer by one slot, and the step
// taken from the last slot sets full.
// Assumes: dir_down is stable between clears.
module lcdcap_slot_ptr
    import lcdcap_pkg::*;
#(
    parameter int unsigned SLOTS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dir_down,
    input  logic             adv,
    output logic [SLOTS-1:0] sel,
    output logic             full
);

    localparam logic [SLOTS-1:0] FIRST_UP   = SLOTS'(1);
    localparam logic [SLOTS-1:0] FIRST_DOWN = SLOTS'(1) << (SLOTS - 1);

    logic [SLOTS-1:0] start_sel;
    logic             at_last;

    // Choose the starting slot and the final slot for the travel direction.
    always_comb begin
        if (scan_dir_e'(dir_down) == SCAN_DOWN) begin
            start_sel = FIRST_DOWN;
            at_last   = sel[0];
        end else begin
            start_sel = FIRST_UP;
            at_last   = sel[SLOTS-1];
        end
    end

    // Pointer and full flag: reload on clear, step on every written byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sel  <= start_sel;
            full <= 1'b0;
        end else if (adv) begin
            if (scan_dir_e'(dir_down) == SCAN_DOWN) begin
                sel <= sel >> 1;
            end else begin
                sel <= sel << 1;
            end
            if (at_last) begin
                full <= 1'b1;
            end
        end
    end

    assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_adv_has_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> $onehot(sel));

    assert_full_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

endmodule

// File: rtl/lcdcap_data_latch.sv
// Module: lcdcap_data_latch
// Bank of byte slots. A write stores wdata into every slot whose select bit
// is set. Slot k sits at bits k*SLOT_W upward in q.
// Assumes: sel has at most one bit set.
module lcdcap_data_latch
    import lcdcap_pkg::*;
#(
    parameter int unsigned SLOTS  = 20,
    parameter int unsigned SLOT_W = SLOT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [SLOTS-1:0]        sel,
    input  logic [SLOT_W-1:0]       wdata,
    output logic [SLOTS*SLOT_W-1:0] q
);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // One slot: clear on reset, load when written and selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[k*SLOT_W +: SLOT_W] <= '0;
            end else if (wr && sel[k]) begin
                q[k*SLOT_W +: SLOT_W] <= wdata;
            end
        end
    end

    assert_no_write_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));

endmodule

// File: rtl/lcdcap_column_capture.sv
// Module: lcdcap_column_capture
// Top of the column capture block. It decides which strobes are taken
// (enable handshake, line clear, full line), routes bytes into the latch
// through the one-hot pointer, drives the cascade output and copies the
// latch into the line latch when the line pulse falls.
// Assumes: shift_stb marks shift-clock falling edges, one cycle each;
// bus_byte and scan_down change only while line_pulse is high.
module lcdcap_column_capture
    import lcdcap_pkg::*;
#(
    parameter int unsigned SLOTS  = 20,
    parameter int unsigned SLOT_W = SLOT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_pulse,
    input  logic                    en_in_n,
    input  logic                    shift_stb,
    input  logic                    bus_byte,
    input  logic                    scan_down,
    input  logic [SLOT_W-1:0]       din,
    output logic                    casc_out_n,
    output logic [SLOTS*SLOT_W-1:0] line_out
);

    localparam int unsigned LINE_W = SLOTS * SLOT_W;

    logic              lp_q;
    logic              active_q;
    logic              take;
    logic              lp_fall;
    logic              byte_vld;
    logic [SLOT_W-1:0] byte_val;
    logic [SLOTS-1:0]  slot_sel;
    logic              line_full;
    logic [LINE_W-1:0] latch_q;

    // Gate strobes: not during a line pulse, not once full, and only with enable.
    always_comb begin
        take    = shift_stb & ~line_pulse & ~line_full & (active_q | ~en_in_n);
        lp_fall = lp_q & ~line_pulse;
    end

    // Line pulse history, used to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
        end else begin
            lp_q <= line_pulse;
        end
    end

    // Selection state: set by the first enabled strobe, cleared by the line pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || line_pulse) begin
            active_q <= 1'b0;
        end else if (take) begin
            active_q <= 1'b1;
        end
    end

    lcdcap_bus_conv #(
        .SLOT_W (SLOT_W)
    ) u_bus_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (line_pulse),
        .take      (take),
        .byte_mode (bus_byte),
        .din       (din),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val)
    );

    lcdcap_slot_ptr #(
        .SLOTS (SLOTS)
    ) u_slot_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (line_pulse),
        .dir_down (scan_down),
        .adv      (byte_vld),
        .sel      (slot_sel),
        .full     (line_full)
    );

    lcdcap_data_latch #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_data_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (byte_vld),
        .sel   (slot_sel),
        .wdata (byte_val),
        .q     (latch_q)
    );

    // Cascade enable to the next driver: low once this line is full.
    assign casc_out_n = ~line_full;

    // Line latch: load the whole data latch when the line pulse falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= '0;
        end else if (lp_fall) begin
            line_out <= latch_q;
        end
    end

    assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_q && !line_pulse) |=> $stable(line_out));

    assert_casc_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |=> casc_out_n);

    assert_casc_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(casc_out_n) |-> $past(byte_vld));

    assert_full_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc_out_n && !line_pulse) |=> $stable(latch_q));

    assert_wait_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && en_in_n) |-> !byte_vld);

endmodule

// File: tb/lcdcap_column_capture_bench.sv
module lcdcap_column_capture_bench;

    localparam int SLOTS  = 20;
    localparam int LINE_W = SLOTS * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_pulse = 1'b0;
    logic              en_in_n = 1'b1;
    logic              shift_stb = 1'b0;
    logic              bus_byte = 1'b1;
    logic              scan_down = 1'b0;
    logic [7:0]        din = 8'h00;
    logic              casc_out_n;
    logic [LINE_W-1:0] line_out;

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;

    // Reference model state
    logic [7:0]        m_slot [SLOTS];
    logic [LINE_W-1:0] m_line;
    bit                m_active, m_phase, m_done, m_lpq;
    logic [3:0]        m_lo;
    int                m_cnt;

    lcdcap_column_capture u_lcdcap_column_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .en_in_n    (en_in_n),
        .shift_stb  (shift_stb),
        .bus_byte   (bus_byte),
        .scan_down  (scan_down),
        .din        (din),
        .casc_out_n (casc_out_n),
        .line_out   (line_out)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [LINE_W-1:0] got, logic [LINE_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic void model_write(logic [7:0] b);
        int slot = scan_down ? (SLOTS - 1 - m_cnt) : m_cnt;
        m_slot[slot] = b;
        m_cnt++;
        if (m_cnt == SLOTS) m_done = 1'b1;
    endfunction

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_slot[k]) m_slot[k] = 8'h00;
            m_line = '0; m_active = 0; m_phase = 0; m_done = 0; m_lpq = 0;
            m_lo = 4'h0; m_cnt = 0;
        end else begin
            if (m_lpq && !line_pulse) begin
                for (int k = 0; k < SLOTS; k++) m_line[k*8 +: 8] = m_slot[k];
            end
            if (line_pulse) begin
                m_active = 0; m_phase = 0; m_cnt = 0; m_done = 0;
            end else if (shift_stb && !m_done && (m_active || !en_in_n)) begin
                m_active = 1;
                if (bus_byte) begin
                    model_write(din);
                end else if (!m_phase) begin
                    m_lo = din[3:0];
                    m_phase = 1;
                end else begin
                    model_write({din[3:0], m_lo});
                    m_phase = 0;
                end
            end
            m_lpq = line_pulse;
        end
    end

    // Compare outputs with the model on every falling edge (R6, R8)
    always @(negedge clk) begin
        if (compare_on) begin
            check("R6 casc_out_n", LINE_W'(casc_out_n), LINE_W'(!m_done));
            check("R8 line_out", line_out, m_line);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_line(bit mode8, bit down);
        @(negedge clk);
        line_pulse = 1'b1; bus_byte = mode8; scan_down = down;
        idle(2);
        line_pulse = 1'b0;
        idle(2);
    endtask

    task automatic strobe(logic [7:0] d, bit en_n);
        @(negedge clk);
        shift_stb = 1'b1; din = d; en_in_n = en_n;
        @(negedge clk);
        shift_stb = 1'b0; en_in_n = 1'b1;
    endtask

    task automatic send_nibbles(logic [7:0] b, bit en_n);
        strobe({4'h0, b[3:0]}, en_n);
        strobe({4'h0, b[7:4]}, 1'b1);
    endtask

    initial begin
        idle(3);
        // R1: reset values
        check("R1 line_out", line_out, '0);
        check("R1 casc_out_n", LINE_W'(casc_out_n), LINE_W'(1));
        rst_n = 1'b1;
        compare_on = 1'b1;

        // Line A: byte mode, upward, strobes before enable are ignored (R5)
        pulse_line(1'b1, 1'b0);
        strobe(8'hFF, 1'b1);
        strobe(8'hFE, 1'b1);
        idle(1);
        check("R5 casc before enable", LINE_W'(casc_out_n), LINE_W'(1));
        strobe(8'hA0, 1'b0);
        for (int k = 1; k < SLOTS; k++) strobe(8'hA0 + 8'(k), 1'b1);
        idle(1);
        check("R6 casc low when full", LINE_W'(casc_out_n), LINE_W'(0));
        // R7: extra strobes after full
        strobe(8'h55, 1'b0);
        strobe(8'h66, 1'b1);
        check("R8 line_out held before pulse", line_out, '0);
        pulse_line(1'b0, 1'b1);
        check("R6 casc released", LINE_W'(casc_out_n), LINE_W'(1));
        check("R2 R4 slot0", LINE_W'(line_out[7:0]), LINE_W'(8'hA0));
        check("R2 R4 slot19", LINE_W'(line_out[159:152]), LINE_W'(8'hB3));
        check("R5 R7 slot1", LINE_W'(line_out[15:8]), LINE_W'(8'hA1));
        check("R8 whole line", line_out, m_line);

        // Line B: nibble mode, downward (set by the pulse above)
        send_nibbles(8'h10, 1'b0);
        for (int k = 1; k < SLOTS; k++) send_nibbles(8'h10 + 8'(k * 7), 1'b1);
        idle(1);
        check("R3 casc low when full", LINE_W'(casc_out_n), LINE_W'(0));
        check("R8 line_out held during capture", LINE_W'(line_out[7:0]), LINE_W'(8'hA0));
        pulse_line(1'b1, 1'b0);
        check("R3 R4 slot19 first byte", LINE_W'(line_out[159:152]), LINE_W'(8'h10));
        check("R3 R4 slot0 last byte", LINE_W'(line_out[7:0]), LINE_W'(8'h10 + 8'(19 * 7)));

        // R9: a line cut short, then a fresh line
        strobe(8'hC0, 1'b0);
        strobe(8'hC1, 1'b1);
        strobe(8'hC2, 1'b1);
        pulse_line(1'b0, 1'b0);
        check("R9 partial slot2", LINE_W'(line_out[23:16]), LINE_W'(8'hC2));
        check("R9 partial slot3 kept", LINE_W'(line_out[31:24]), LINE_W'(m_slot[3]));
        // A single nibble, then a pulse: the pairing must restart
        strobe(8'h0E, 1'b0);
        pulse_line(1'b0, 1'b0);
        strobe(8'h07, 1'b1);
        idle(1);
        check("R9 enable cleared by pulse", LINE_W'(casc_out_n), LINE_W'(1));
        send_nibbles(8'h3C, 1'b0);
        for (int k = 1; k < SLOTS; k++) send_nibbles(8'h3C ^ 8'(k), 1'b1);
        pulse_line(1'b1, 1'b0);
        check("R9 R3 slot0 realigned", LINE_W'(line_out[7:0]), LINE_W'(8'h3C));
        check("R9 whole line", line_out, m_line);

        // R1: reset in mid-line clears everything
        strobe(8'h99, 1'b0);
        @(negedge clk); rst_n = 1'b0; compare_on = 1'b0;
        idle(2);
        check("R1 line_out after reset", line_out, '0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        pulse_line(1'b1, 1'b0);
        check("R1 latch cleared", line_out, '0);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule